// File: doc/BRIEF.md
# Page-Wrapping Word Address Counter

This block is the word-address pointer of a byte-wide serial memory of 512 pages of 128 bytes each, which gives a 16-bit address. The protocol front end loads it from two received address bytes, high byte first. It then strobes the pointer once after each data byte is written or read. The pointer always shows the location of the next byte to access. It keeps that value between transactions, so a read that sends no address continues one byte past the last byte touched.

The increment wraps differently for the two directions. A write step changes only the in-page offset (bits 6:0), so a page write that runs past the end of its page starts again at the first byte of the same page. A read step moves across the whole array and rolls over from the top address to zero. A load in a cycle overrides any increment in that cycle.

Top module: `page_wrap_addr_ctr`

## Requirements
- R1: While `rst` is high at a clock edge, the address becomes 0x0000 at that edge.
- R2: `load_hi` writes `din` into address bits 15:8 at the next edge. Bits 7:0 do not change unless `load_lo` is also high.
- R3: `load_lo` writes `din` into address bits 7:0 at the next edge. Bits 15:8 do not change unless `load_hi` is also high.
- R4: In a cycle with any load strobe, no increment takes place, even if `inc_write` or `inc_read` is also high. The byte that is not loaded keeps its value. When both load strobes are high, both bytes take `din`.
- R5: `inc_write` with no load adds one to bits 6:0 at the next edge, and bits 15:7 stay unchanged.
- R6: `inc_write` at in-page offset 127 sets the offset to 0 in the same page (for example 0x12FF becomes 0x1280). A run of more than 128 write steps therefore cycles through the same page.
- R7: `inc_read` with no load adds one to the full 16-bit address, and the carry crosses page boundaries (0x127F becomes 0x1280).
- R8: `inc_read` at 0xFFFF gives 0x0000.
- R9: With no strobe high, the address holds its value for any number of cycles.
- R10: When `inc_write` and `inc_read` are both high with no load, the write (in-page) step is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_hi | input | 1 | Load `din` into the high address byte |
| load_lo | input | 1 | Load `din` into the low address byte |
| inc_write | input | 1 | Advance after a written byte, with in-page wrap |
| inc_read | input | 1 | Advance after a read byte, with whole-array wrap |
| din | input | 8 | Received address byte |
| addr | output | 16 | Current word address (registered) |

## Verification
The address is one register stage. Each strobe, load or reset sampled at an edge shows its full effect on `addr` right after that same edge, and nothing is due later. The bench changes inputs on the falling edge. It checks `addr` 1 ns after the next rising edge, so every comparison sees the result of exactly one sampled command. Sequences such as the 130-step page write chain these one-cycle results, and the expected offset is recomputed modulo 128 at each step.

// File: rtl/addr_ptr_pkg.sv
package addr_ptr_pkg;

    localparam int unsigned DEF_PTR_W  = 16;
    localparam int unsigned DEF_LANE_W = 8;
    localparam int unsigned DEF_OFS_W  = 7;

    typedef enum logic [1:0] {
        STEP_HOLD  = 2'd0,
        STEP_PAGE  = 2'd1,
        STEP_ARRAY = 2'd2
    } step_e;

    typedef struct packed {
        logic  load;
        step_e step;
    } ptr_cmd_t;

    function automatic ptr_cmd_t make_cmd(input logic any_load,
                                          input logic wr_step,
                                          input logic rd_step);
        ptr_cmd_t c;
        c.load = any_load;
        if (wr_step)      c.step = STEP_PAGE;
        else if (rd_step) c.step = STEP_ARRAY;
        else              c.step = STEP_HOLD;
        return c;
    endfunction

endpackage

// File: rtl/ptr_cmd_decode.sv
module ptr_cmd_decode
    import addr_ptr_pkg::*;
#(
    parameter int unsigned LANES = 2
) (
    input  logic             load_hi,
    input  logic             load_lo,
    input  logic             inc_write,
    input  logic             inc_read,
    output logic [LANES-1:0] lane_load,
    output ptr_cmd_t         cmd
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        if (i == LANES - 1) begin : g_top
            assign lane_load[i] = load_hi;
        end else if (i == 0) begin : g_bot
            assign lane_load[i] = load_lo;
        end else begin : g_mid
            assign lane_load[i] = 1'b0;
        end
    end

    assign cmd = make_cmd(load_hi | load_lo, inc_write, inc_read);

endmodule

// File: rtl/ptr_next_calc.sv
module ptr_next_calc
    import addr_ptr_pkg::*;
#(
    parameter int unsigned PTR_W  = DEF_PTR_W,
    parameter int unsigned LANE_W = DEF_LANE_W,
    parameter int unsigned OFS_W  = DEF_OFS_W
) (
    input  logic [PTR_W-1:0]        cur,
    input  logic [LANE_W-1:0]       din,
    input  logic [PTR_W/LANE_W-1:0] lane_load,
    input  ptr_cmd_t                cmd,
    output logic [PTR_W-1:0]        nxt
);

    localparam int unsigned LANES = PTR_W / LANE_W;

    logic [PTR_W-1:0] stepped;

    always_comb begin
        stepped = cur;
        if (!cmd.load) begin
            case (cmd.step)
                STEP_PAGE:  stepped = {cur[PTR_W-1:OFS_W], cur[OFS_W-1:0] + OFS_W'(1)};
                STEP_ARRAY: stepped = cur + PTR_W'(1);
                default:    stepped = cur;
            endcase
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_mux
        assign nxt[i*LANE_W +: LANE_W] = lane_load[i] ? din : stepped[i*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/ptr_reg.sv
module ptr_reg #(
    parameter int unsigned PTR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PTR_W-1:0] nxt,
    output logic [PTR_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

endmodule

// File: rtl/page_wrap_addr_ctr.sv
module page_wrap_addr_ctr
    import addr_ptr_pkg::*;
#(
    parameter int unsigned PTR_W  = DEF_PTR_W,
    parameter int unsigned LANE_W = DEF_LANE_W,
    parameter int unsigned OFS_W  = DEF_OFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_hi,
    input  logic              load_lo,
    input  logic              inc_write,
    input  logic              inc_read,
    input  logic [LANE_W-1:0] din,
    output logic [PTR_W-1:0]  addr
);

    localparam int unsigned LANES = PTR_W / LANE_W;

    logic [LANES-1:0] lane_load;
    ptr_cmd_t         cmd;
    logic [PTR_W-1:0] nxt;

    ptr_cmd_decode #(.LANES(LANES)) u_dec (
        .load_hi   (load_hi),
        .load_lo   (load_lo),
        .inc_write (inc_write),
        .inc_read  (inc_read),
        .lane_load (lane_load),
        .cmd       (cmd)
    );

    ptr_next_calc #(.PTR_W(PTR_W), .LANE_W(LANE_W), .OFS_W(OFS_W)) u_calc (
        .cur       (addr),
        .din       (din),
        .lane_load (lane_load),
        .cmd       (cmd),
        .nxt       (nxt)
    );

    ptr_reg #(.PTR_W(PTR_W)) u_reg (
        .clk (clk),
        .rst (rst),
        .nxt (nxt),
        .q   (addr)
    );

endmodule

// File: rtl/ptr_checker.sv
module ptr_checker #(
    parameter int unsigned PTR_W  = 16,
    parameter int unsigned LANE_W = 8,
    parameter int unsigned OFS_W  = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              load_hi,
    input logic              load_lo,
    input logic              inc_write,
    input logic              inc_read,
    input logic [LANE_W-1:0] din,
    input logic [PTR_W-1:0]  addr
);

    logic no_load;
    assign no_load = !load_hi && !load_lo;

    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> addr == '0);

    assert_load_high_R2: assert property (@(posedge clk) disable iff (rst)
        load_hi |=> addr[PTR_W-1:PTR_W-LANE_W] == $past(din));

    assert_load_low_R3: assert property (@(posedge clk) disable iff (rst)
        load_lo |=> addr[LANE_W-1:0] == $past(din));

    assert_load_no_step_R4: assert property (@(posedge clk) disable iff (rst)
        (load_hi && !load_lo) |=> addr[LANE_W-1:0] == $past(addr[LANE_W-1:0]));

    assert_write_page_R5: assert property (@(posedge clk) disable iff (rst)
        (no_load && inc_write) |=>
            addr[PTR_W-1:OFS_W] == $past(addr[PTR_W-1:OFS_W]) &&
            addr[OFS_W-1:0] == $past(addr[OFS_W-1:0]) + OFS_W'(1));

    assert_write_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        (no_load && inc_write && addr[OFS_W-1:0] == '1) |=> addr[OFS_W-1:0] == '0);

    assert_read_step_R7: assert property (@(posedge clk) disable iff (rst)
        (no_load && !inc_write && inc_read) |=> addr == $past(addr) + PTR_W'(1));

    assert_read_top_wrap_R8: assert property (@(posedge clk) disable iff (rst)
        (no_load && !inc_write && inc_read && addr == '1) |=> addr == '0);

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (no_load && !inc_write && !inc_read) |=> $stable(addr));

    assert_write_beats_read_R10: assert property (@(posedge clk) disable iff (rst)
        (no_load && inc_write && inc_read) |=>
            addr[PTR_W-1:OFS_W] == $past(addr[PTR_W-1:OFS_W]));

endmodule

bind page_wrap_addr_ctr ptr_checker #(.PTR_W(PTR_W), .LANE_W(LANE_W), .OFS_W(OFS_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .load_hi   (load_hi),
    .load_lo   (load_lo),
    .inc_write (inc_write),
    .inc_read  (inc_read),
    .din       (din),
    .addr      (addr)
);

// File: tb/tb_page_wrap_addr_ctr.sv
`timescale 1ns/1ps
module tb_page_wrap_addr_ctr;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_hi = 1'b0, load_lo = 1'b0, inc_write = 1'b0, inc_read = 1'b0;
    logic [7:0]  din = 8'h00;
    logic [15:0] addr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    page_wrap_addr_ctr dut (
        .clk(clk), .rst(rst), .load_hi(load_hi), .load_lo(load_lo),
        .inc_write(inc_write), .inc_read(inc_read), .din(din), .addr(addr)
    );

    // {req[3:0], strobes {load_hi,load_lo,inc_write,inc_read}, din[7:0], expected addr[15:0]}
    localparam logic [31:0] VEC [16] = '{
        32'h28121200,  // R2 high byte load
        32'h34FE12FE,  // R3 low byte load
        32'h520012FF,  // R5 write step
        32'h62001280,  // R6 in-page wrap 0x12FF -> 0x1280
        32'h52001281,  // R5 write step after wrap
        32'h71001282,  // R7 read step
        32'h347F127F,  // R3 low byte load
        32'h71001280,  // R7 read carry across page
        32'h90001280,  // R9 idle hold
        32'h49FFFF80,  // R4 load_hi beats inc_read
        32'h46FFFFFF,  // R4 load_lo beats inc_write
        32'h81000000,  // R8 read wrap 0xFFFF -> 0
        32'h347F007F,  // R3 low byte load
        32'hA3000000,  // R10 both steps: in-page wrap, not 0x0080
        32'h90000000,  // R9 idle hold
        32'h4E5A5A5A   // R4 both loads plus inc_write
    };

    task automatic check(input string req, input logic [15:0] exp);
        checks++;
        if (addr !== exp) begin
            failures++;
            $display("FAIL %s addr=%h expected=%h", req, addr, exp);
        end
    endtask

    task automatic apply(input logic [3:0] stb, input logic [7:0] d);
        @(negedge clk);
        {load_hi, load_lo, inc_write, inc_read} = stb;
        din = d;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", 16'h0000);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < 16; i++) begin
            apply(VEC[i][27:24], VEC[i][23:16]);
            check($sformatf("R%0d", VEC[i][31:28]), VEC[i][15:0]);
        end

        // R1: reset in the middle of use clears the pointer
        apply(4'b0100, 8'h33);
        @(negedge clk);
        rst = 1'b1;
        {load_hi, load_lo, inc_write, inc_read} = 4'b0000;
        @(posedge clk);
        #1;
        check("R1", 16'h0000);
        @(negedge clk);
        rst = 1'b0;

        // R6: 130-byte page write from offset 5 stays in page 0x3400
        apply(4'b1000, 8'h34);
        apply(4'b0100, 8'h05);
        check("R3", 16'h3405);
        for (int k = 1; k <= 130; k++) begin
            apply(4'b0010, 8'h00);
            check("R6", 16'h3400 | 16'((5 + k) % 128));
        end
        check("R6", 16'h3407);

        // R9: several idle cycles keep the value
        for (int k = 0; k < 4; k++) begin
            apply(4'b0000, 8'hC3);
            check("R9", 16'h3407);
        end

        // R7: read steps continue from the last write position
        apply(4'b0001, 8'h00);
        check("R7", 16'h3408);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule